// File: doc/BRIEF.md
# Scalar Bit-Manipulation Unit

This block is a scalar ALU with one source operand that carries out bit-manipulation operations in 32-bit ("half") and 64-bit ("full") forms. It covers counting of set or clear bits and index searches from the least significant end. It also covers leading-bit searches from the most significant end, both unsigned and relative to the sign, along with bit mirroring and nibble-group reduction and expansion. Single-bit insertion and removal in an old destination value and sign widening of a byte or halfword complete the set. Each cycle it takes an opcode, a 64-bit source and a 64-bit old destination value. The result is registered and appears one clock later, together with a condition-code write enable and a condition-code value.

Each operation first moves its operand into a shared form. The source may be inverted, mirrored, folded against its sign bit or masked to the low half. The shared form then goes through one of three datapath units: a population counter, a lowest-set-bit scanner and a nibble reducer. The operand is folded so that every search becomes a scan for the lowest set bit. The 32-bit forms always return zero in bits 63:32. Searches that find nothing return 32'hFFFF_FFFF, zero-extended. Opcodes not listed below produce a zero result with the condition code untouched.

Top module: `sbm_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the outputs after that edge are `result_o`=0, `cc_we_o`=0 and `cc_val_o`=0.
- R2: The outputs after rising edge k are a function only of `op_i`, `src_i` and `old_i` sampled at edge k (one cycle of latency).
- R3: Opcodes 10/11 count the clear bits and 12/13 count the set bits of the low 32 bits / all 64 bits. The count is zero-extended, `cc_we_o`=1 and `cc_val_o` = (count != 0).
- R4: Opcodes 14/15 return the index of the lowest clear bit and 16/17 the index of the lowest set bit, over 32 / 64 bits. If no such bit exists the result is 64'h0000_0000_FFFF_FFFF.
- R5: Opcodes 18/19 return the number of bits passed from the top bit (31 / 63) down to the first set bit, so a set top bit gives 0. A zero operand gives 64'h0000_0000_FFFF_FFFF.
- R6: Opcodes 20/21 return the number of bits passed from the top bit down to the first bit that differs from the top bit. If every bit equals the top bit the result is 64'h0000_0000_FFFF_FFFF.
- R7: Opcodes 8/9 return the operand with its bit order mirrored over 32 / 64 bits, and `cc_we_o` stays 0.
- R8: Opcodes 40/41 set result bit g when source nibble g (bits 4g+3..4g) is non-zero, for g < 8 / g < 16. The other result bits are 0, `cc_we_o`=1 and `cc_val_o` = (result != 0).
- R9: Opcodes 6/7 set each result nibble to 4'hF when the matching source nibble is non-zero and to 0 otherwise, over 32 / 64 bits. `cc_we_o`=1 and `cc_val_o` = (result != 0).
- R10: Opcodes 24/25 clear and 26/27 set one bit of `old_i`, whose index is `src_i[4:0]` / `src_i[5:0]`. The half forms keep only bits 31:0 of `old_i`.
- R11: Opcodes 22/23 sign-extend `src_i[7:0]` / `src_i[15:0]` to 32 bits, zero-extended to 64.
- R12: All half forms (the even opcodes above and 22, 23) drive `result_o[63:32]`=0. Any opcode not listed gives `result_o`=0 and `cc_we_o`=0.
- R13: `cc_we_o` is 1 only for opcodes 6, 7, 10–13, 40 and 41. Whenever it is 1, `cc_val_o` = (`result_o` != 0), and whenever it is 0, `cc_val_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 6 | Operation code |
| src_i | input | 64 | Source operand |
| old_i | input | 64 | Old destination value for bit set/clear |
| result_o | output | 64 | Registered result |
| cc_we_o | output | 1 | Condition-code write enable |
| cc_val_o | output | 1 | Condition-code value |

## Verification
Each of the 64 opcode values is driven with the same operand set. The set includes zero and all-ones, which expose the not-found sentinel and both sign polarities of the signed leading search. Single set bits at positions 0, 31, 32 and 63 separate half from full width and catch off-by-one errors in the search directions. Words whose upper half differs from the lower half show whether a half form leaks upper bits, and operands whose low six bits are 31, 32 or 63 tell the 5-bit index from the 6-bit one. Seeded random words then mix nibble patterns for the mask operations. A behavioural model computes every expected value one cycle after it is driven.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

    localparam int OP_W = 6;

    typedef enum logic [OP_W-1:0] {
        OP_WQM_H  = 6'd6,
        OP_WQM_F  = 6'd7,
        OP_REV_H  = 6'd8,
        OP_REV_F  = 6'd9,
        OP_CNT0_H = 6'd10,
        OP_CNT0_F = 6'd11,
        OP_CNT1_H = 6'd12,
        OP_CNT1_F = 6'd13,
        OP_FZ_H   = 6'd14,
        OP_FZ_F   = 6'd15,
        OP_FO_H   = 6'd16,
        OP_FO_F   = 6'd17,
        OP_LEAD_H = 6'd18,
        OP_LEAD_F = 6'd19,
        OP_LDS_H  = 6'd20,
        OP_LDS_F  = 6'd21,
        OP_SX8    = 6'd22,
        OP_SX16   = 6'd23,
        OP_CLR_H  = 6'd24,
        OP_CLR_F  = 6'd25,
        OP_SET_H  = 6'd26,
        OP_SET_F  = 6'd27,
        OP_QM_H   = 6'd40,
        OP_QM_F   = 6'd41
    } sbm_op_e;

endpackage

// File: rtl/sbm_popcnt.sv
module sbm_popcnt #(
    parameter int W  = 64,
    parameter int CW = $clog2(W) + 1
) (
    input  logic [W-1:0]  vec_i,
    output logic [CW-1:0] cnt_o
);

    always_comb begin
        cnt_o = '0;
        for (int i = 0; i < W; i++) begin
            cnt_o = cnt_o + CW'(vec_i[i]);
        end
    end

endmodule

// File: rtl/sbm_lsb_scan.sv
module sbm_lsb_scan #(
    parameter int W  = 64,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);

    always_comb begin
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                idx_o = IW'(i);
            end
        end
    end

    assign found_o = |vec_i;

endmodule

// File: rtl/sbm_nibble.sv
module sbm_nibble #(
    parameter int W  = 64,
    parameter int NG = W / 4
) (
    input  logic [W-1:0]  vec_i,
    output logic [NG-1:0] any_o,
    output logic [W-1:0]  wide_o
);

    for (genvar g = 0; g < NG; g++) begin : g_grp
        assign any_o[g]         = |vec_i[4*g +: 4];
        assign wide_o[4*g +: 4] = {4{any_o[g]}};
    end

endmodule

// File: rtl/sbm_unit.sv
module sbm_unit
    import sbm_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [5:0]    op_i,
    input  logic [DW-1:0] src_i,
    input  logic [DW-1:0] old_i,
    output logic [DW-1:0] result_o,
    output logic          cc_we_o,
    output logic          cc_val_o
);

    localparam int HW  = DW / 2;
    localparam int CW  = $clog2(DW) + 1;
    localparam int IW  = $clog2(DW);
    localparam int NG  = DW / 4;
    localparam int BIH = $clog2(HW);
    localparam int BIF = $clog2(DW);

    sbm_op_e op;
    assign op = sbm_op_e'(op_i);

    logic [HW-1:0] lo, sgn_h, rev_h, rsg_h;
    logic [DW-1:0] sgn_f, rev_f, rsg_f;
    logic [DW-1:0] cnt_vec, scan_vec, nib_vec;
    logic [DW-1:0] lo_ext;
    logic [CW-1:0] cnt;
    logic          found;
    logic [IW-1:0] idx;
    logic [NG-1:0] nib_any;
    logic [DW-1:0] nib_wide;
    logic [DW-1:0] nxt_res;
    logic          nxt_we, nxt_cv;
    logic [DW-1:0] sentinel, found_res;
    logic [HW-1:0] oh_h;
    logic [DW-1:0] oh_f;

    assign lo       = src_i[HW-1:0];
    assign lo_ext   = {{HW{1'b0}}, lo};
    assign sentinel = {{HW{1'b0}}, {HW{1'b1}}};
    assign oh_h     = {{(HW-1){1'b0}}, 1'b1} << src_i[BIH-1:0];
    assign oh_f     = {{(DW-1){1'b0}}, 1'b1} << src_i[BIF-1:0];

    // operand folding: sign fold and mirroring
    always_comb begin
        sgn_f = src_i ^ {DW{src_i[DW-1]}};
        sgn_h = lo ^ {HW{lo[HW-1]}};
        for (int i = 0; i < DW; i++) begin
            rev_f[i] = src_i[DW-1-i];
            rsg_f[i] = sgn_f[DW-1-i];
        end
        for (int i = 0; i < HW; i++) begin
            rev_h[i] = lo[HW-1-i];
            rsg_h[i] = sgn_h[HW-1-i];
        end
    end

    // select the vector each shared unit sees
    always_comb begin
        cnt_vec  = src_i;
        scan_vec = src_i;
        nib_vec  = src_i;
        unique case (op)
            OP_CNT0_H: cnt_vec  = {{HW{1'b0}}, ~lo};
            OP_CNT0_F: cnt_vec  = ~src_i;
            OP_CNT1_H: cnt_vec  = lo_ext;
            OP_FZ_H:   scan_vec = {{HW{1'b0}}, ~lo};
            OP_FZ_F:   scan_vec = ~src_i;
            OP_FO_H:   scan_vec = lo_ext;
            OP_LEAD_H: scan_vec = {{HW{1'b0}}, rev_h};
            OP_LEAD_F: scan_vec = rev_f;
            OP_LDS_H:  scan_vec = {{HW{1'b0}}, rsg_h};
            OP_LDS_F:  scan_vec = rsg_f;
            OP_QM_H,
            OP_WQM_H:  nib_vec  = lo_ext;
            default: ;
        endcase
    end

    sbm_popcnt #(.W(DW), .CW(CW)) u_cnt (
        .vec_i (cnt_vec),
        .cnt_o (cnt)
    );

    sbm_lsb_scan #(.W(DW), .IW(IW)) u_scan (
        .vec_i   (scan_vec),
        .found_o (found),
        .idx_o   (idx)
    );

    sbm_nibble #(.W(DW), .NG(NG)) u_nib (
        .vec_i  (nib_vec),
        .any_o  (nib_any),
        .wide_o (nib_wide)
    );

    assign found_res = found ? {{(DW-IW){1'b0}}, idx} : sentinel;

    // result and condition-code selection
    always_comb begin
        nxt_res = '0;
        nxt_we  = 1'b0;
        nxt_cv  = 1'b0;
        unique case (op)
            OP_CNT0_H, OP_CNT0_F, OP_CNT1_H, OP_CNT1_F: begin
                nxt_res = {{(DW-CW){1'b0}}, cnt};
                nxt_we  = 1'b1;
                nxt_cv  = |cnt;
            end
            OP_FZ_H, OP_FZ_F, OP_FO_H, OP_FO_F,
            OP_LEAD_H, OP_LEAD_F, OP_LDS_H, OP_LDS_F: begin
                nxt_res = found_res;
            end
            OP_REV_H: nxt_res = {{HW{1'b0}}, rev_h};
            OP_REV_F: nxt_res = rev_f;
            OP_QM_H, OP_QM_F: begin
                nxt_res = {{(DW-NG){1'b0}}, nib_any};
                nxt_we  = 1'b1;
                nxt_cv  = |nib_any;
            end
            OP_WQM_H, OP_WQM_F: begin
                nxt_res = nib_wide;
                nxt_we  = 1'b1;
                nxt_cv  = |nib_any;
            end
            OP_CLR_H: nxt_res = {{HW{1'b0}}, old_i[HW-1:0] & ~oh_h};
            OP_CLR_F: nxt_res = old_i & ~oh_f;
            OP_SET_H: nxt_res = {{HW{1'b0}}, old_i[HW-1:0] | oh_h};
            OP_SET_F: nxt_res = old_i | oh_f;
            OP_SX8:   nxt_res = {{HW{1'b0}}, {(HW-8){src_i[7]}}, src_i[7:0]};
            OP_SX16:  nxt_res = {{HW{1'b0}}, {(HW-16){src_i[15]}}, src_i[15:0]};
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_o <= '0;
            cc_we_o  <= 1'b0;
            cc_val_o <= 1'b0;
        end else begin
            result_o <= nxt_res;
            cc_we_o  <= nxt_we;
            cc_val_o <= nxt_cv;
        end
    end

endmodule

// File: rtl/sbm_unit_chk.sv
module sbm_unit_chk
    import sbm_pkg::*;
#(
    parameter int DW = 64
) (
    input logic          clk,
    input logic          rst,
    input logic [5:0]    op_i,
    input logic [DW-1:0] src_i,
    input logic [DW-1:0] old_i,
    input logic [DW-1:0] result_o,
    input logic          cc_we_o,
    input logic          cc_val_o
);

    localparam int HW  = DW / 2;
    localparam int BIF = $clog2(DW);

    bit primed = 1'b0;
    always_ff @(posedge clk) primed <= !rst;

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (result_o == '0 && !cc_we_o && !cc_val_o));

    p_find_none_r4: assert property (@(posedge clk) disable iff (rst || !primed)
        ($past(op_i) == OP_FO_F && $past(src_i) == '0)
        |-> result_o == {{HW{1'b0}}, {HW{1'b1}}});

    p_rev_no_cc_r7: assert property (@(posedge clk) disable iff (rst || !primed)
        ($past(op_i) == OP_REV_H || $past(op_i) == OP_REV_F) |-> !cc_we_o);

    p_qm_width_r8: assert property (@(posedge clk) disable iff (rst || !primed)
        ($past(op_i) == OP_QM_F) |-> result_o[DW-1:DW/4] == '0);

    p_set_bit_r10: assert property (@(posedge clk) disable iff (rst || !primed)
        ($past(op_i) == OP_SET_F) |-> result_o[$past(src_i[BIF-1:0])]);

    p_sext_r11: assert property (@(posedge clk) disable iff (rst || !primed)
        ($past(op_i) == OP_SX8) |-> result_o[HW-1:8] == {(HW-8){result_o[7]}});

    p_half_upper_r12: assert property (@(posedge clk) disable iff (rst || !primed)
        ($past(op_i) inside {OP_WQM_H, OP_REV_H, OP_CNT0_H, OP_CNT1_H, OP_FZ_H,
                             OP_FO_H, OP_LEAD_H, OP_LDS_H, OP_SX8, OP_SX16,
                             OP_CLR_H, OP_SET_H, OP_QM_H})
        |-> result_o[DW-1:HW] == '0);

    p_cc_val_r13: assert property (@(posedge clk) disable iff (rst || !primed)
        cc_we_o |-> (cc_val_o == (result_o != '0)));

    p_cc_idle_r13: assert property (@(posedge clk) disable iff (rst || !primed)
        !cc_we_o |-> !cc_val_o);

endmodule

bind sbm_unit sbm_unit_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .op_i     (op_i),
    .src_i    (src_i),
    .old_i    (old_i),
    .result_o (result_o),
    .cc_we_o  (cc_we_o),
    .cc_val_o (cc_val_o)
);

// File: tb/sbm_unit_tb.sv
module sbm_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  op_i = '0;
    logic [63:0] src_i = '0;
    logic [63:0] old_i = '0;
    logic [63:0] result_o;
    logic        cc_we_o, cc_val_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sbm_unit u_dut (
        .clk(clk), .rst(rst), .op_i(op_i), .src_i(src_i), .old_i(old_i),
        .result_o(result_o), .cc_we_o(cc_we_o), .cc_val_o(cc_val_o)
    );

    logic [63:0] exp_res;
    bit          exp_we, exp_cv, pending = 1'b0;
    int          exp_op;

    function automatic string req_of(int op);
        if (op >= 10 && op <= 13) return "R3";
        if (op >= 14 && op <= 17) return "R4";
        if (op == 18 || op == 19) return "R5";
        if (op == 20 || op == 21) return "R6";
        if (op == 8 || op == 9)   return "R7";
        if (op == 40 || op == 41) return "R8";
        if (op == 6 || op == 7)   return "R9";
        if (op >= 24 && op <= 27) return "R10";
        if (op == 22 || op == 23) return "R11";
        return "R12";
    endfunction

    // behavioural reference model
    task automatic model(input int op, input logic [63:0] s, input logic [63:0] o,
                         output logic [63:0] r, output bit we, output bit cv);
        int n;
        n  = op[0] ? 64 : 32;
        r  = '0;
        we = 1'b0;
        case (op)
            10, 11, 12, 13: begin
                int c = 0;
                for (int i = 0; i < n; i++) if (s[i] == (op >= 12)) c++;
                r = 64'(c); we = 1'b1;
            end
            14, 15, 16, 17: begin
                r = 64'hFFFF_FFFF;
                for (int i = 0; i < n; i++)
                    if (s[i] == (op >= 16)) begin r = 64'(i); break; end
            end
            18, 19: begin
                r = 64'hFFFF_FFFF;
                for (int i = n - 1; i >= 0; i--)
                    if (s[i]) begin r = 64'(n - 1 - i); break; end
            end
            20, 21: begin
                r = 64'hFFFF_FFFF;
                for (int i = n - 1; i >= 0; i--)
                    if (s[i] != s[n-1]) begin r = 64'(n - 1 - i); break; end
            end
            8, 9: for (int i = 0; i < n; i++) r[i] = s[n-1-i];
            40, 41: begin
                for (int g = 0; g < n / 4; g++) r[g] = (s[4*g +: 4] != 0);
                we = 1'b1;
            end
            6, 7: begin
                for (int g = 0; g < n / 4; g++) r[4*g +: 4] = (s[4*g +: 4] != 0) ? 4'hF : 4'h0;
                we = 1'b1;
            end
            24, 25, 26, 27: begin
                for (int i = 0; i < n; i++) r[i] = o[i];
                r[s % n] = (op >= 26);
            end
            22: for (int i = 0; i < 32; i++) r[i] = (i < 8) ? s[i] : s[7];
            23: for (int i = 0; i < 32; i++) r[i] = (i < 16) ? s[i] : s[15];
            default: ;
        endcase
        cv = we && (r != 0);
    endtask

    task automatic check_out();
        n_chk++;
        if (result_o !== exp_res) begin
            n_fail++;
            $display("FAIL %s op=%0d result actual=%h expected=%h",
                     req_of(exp_op), exp_op, result_o, exp_res);
        end
        n_chk++;
        if (cc_we_o !== exp_we || cc_val_o !== exp_cv) begin
            n_fail++;
            $display("FAIL R13 op=%0d cc actual=%b/%b expected=%b/%b",
                     exp_op, cc_we_o, cc_val_o, exp_we, exp_cv);
        end
    endtask

    // one vector per cycle; outputs sampled one cycle after driving (R2)
    task automatic step(input int op, input logic [63:0] s, input logic [63:0] o);
        @(negedge clk);
        if (pending) check_out();
        op_i  = 6'(op);
        src_i = s;
        old_i = o;
        exp_op = op;
        model(op, s, o, exp_res, exp_we, exp_cv);
        pending = 1'b1;
    endtask

    logic [63:0] pats [20];

    initial begin
        pats[0]  = 64'h0;
        pats[1]  = '1;
        pats[2]  = 64'h1;
        pats[3]  = 64'h8000_0000_0000_0000;
        pats[4]  = 64'h0000_0000_8000_0000;
        pats[5]  = 64'h0000_0001_0000_0000;
        pats[6]  = 64'hFFFF_FFFF_0000_0000;
        pats[7]  = 64'h0000_0000_FFFF_0F00;
        pats[8]  = 64'h00F0_0000_0001_0000;
        pats[9]  = 64'hFFFF_FFFF_7FFF_FFFF;
        pats[10] = 64'h1234_5678_9ABC_DEF0;
        pats[11] = 64'h0000_0000_0000_003F;
        pats[12] = 64'h0000_0000_0000_001F;
        pats[13] = 64'h0000_0000_0000_0020;
        pats[14] = 64'hFFFF_FFFF_FFFF_FF80;
        pats[15] = 64'h0000_0000_0000_8000;
        for (int i = 16; i < 20; i++) pats[i] = {$urandom(i * 7 + 1), $urandom()};

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_chk++;
        if (result_o !== 64'h0 || cc_we_o !== 1'b0 || cc_val_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset actual=%h/%b/%b expected=0/0/0", result_o, cc_we_o, cc_val_o);
        end
        rst = 1'b0;

        for (int op = 0; op < 64; op++) begin
            for (int p = 0; p < 20; p++) begin
                step(op, pats[p], pats[(p + 7) % 20] ^ 64'h5A5A_A5A5_0F0F_F0F0);
            end
        end
        step(0, 64'h0, 64'h0);
        @(negedge clk);
        check_out();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule